// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets a clocked host read and write an external 32K x 8 asynchronous static RAM. The host presents a request with an address, a write flag and write data while the sequencer signals that it is idle. The sequencer then drives the memory's active-low chip select, output enable and write enable, its 15-bit address bus and the three parts of an 8-bit bidirectional data pin (output value, output enable, input value). It returns a one-cycle completion pulse, together with the captured byte for reads.

All memory timing is met by counting clock cycles. Three parameters set the counts: the number of cycles output enable stays low in a read, the number of cycles write enable stays low in a write, and the number of extra idle cycles placed between a read and a following write so that the memory's output can float before the sequencer drives the pins. With a 20 ns clock, the defaults (3, 2, 1) give 60 ns reads and a 40 ns write pulse. This covers the fast memory grade (55 ns access, 30 ns pulse, 25 ns data setup, 20 ns float time). A slower grade needs larger counts. Address and write data are latched when a request is accepted. Chip select and the latched values stay in place for one cycle after write enable rises.

Top module: `sram_port_ctrl`

## Requirements
- R1: While reset is asserted, and after its release until a request is accepted, chip select, output enable and write enable are high (1), the data driver enable is low, host_idle is 1 and host_done is 0.
- R2: Output enable and write enable are never low in the same cycle, and either one is low only while chip select is low.
- R3: The data driver enable is high only while write enable is low and output enable is high.
- R4: A read holds chip select and output enable low for exactly RD_WAIT cycles. The byte on mem_dq_in at the last of these cycles appears on host_rdata, and host_done is high in the cycle RD_WAIT clock edges after the accepting edge.
- R5: A write holds write enable low for exactly WR_PULSE cycles while driving the latched data and the full latched 15-bit address. host_done follows WR_PULSE+1 edges after the accepting edge, unless R7 applies.
- R6: In the cycle after write enable rises, chip select is still low, the address is unchanged and the driver is off. In the cycle after that, chip select is high.
- R7: A write accepted after a read waits TURN_CYC extra cycles, so host_done comes TURN_CYC+WR_PULSE+1 edges after acceptance. At least TURN_CYC+1 cycles with output enable high separate the end of the read from the start of driving.
- R8: host_done is high for exactly one cycle per accepted request.
- R9: A request is accepted only on an edge where host_idle is 1. A request held while busy is ignored and causes no memory access.
- R10: Address and write data are taken at acceptance. Changes on host_addr or host_wdata during an access do not alter the memory pins.
- R11: A write after a write, and a read after any access, start with no turnaround cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, taken when host_idle is 1 |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 15 | Byte address |
| host_wdata | input | 8 | Write data |
| host_idle | output | 1 | Sequencer can accept a request this cycle |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Captured read data, valid with host_done |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dq_out | output | 8 | Value for the data pins |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 8 | Value read from the data pins |

## Verification
A read completes RD_WAIT edges after the accepting edge. A write completes WR_PULSE+1 edges after acceptance, or TURN_CYC+WR_PULSE+1 edges when a read came just before it. The bench counts edges from acceptance to the first falling-edge sample that shows host_done and compares the count with these figures. It samples each strobe's low time, the post-write hold cycle and the read-to-write gap on falling clock edges, one half period after the registers change. The memory model returns valid data only from the RD_WAIT-th cycle of output enable low, so capturing on any earlier edge yields a wrong byte.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE   = 3'd0,
    SEQ_TURN   = 3'd1,
    SEQ_READ   = 3'd2,
    SEQ_WPULSE = 3'd3,
    SEQ_WHOLD  = 3'd4
  } seq_st_e;

  // Bits needed to hold the value v (at least one)
  function automatic int bits_for(input int v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/sram_port_rstsync.sv
module sram_port_rstsync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;

endmodule

// File: rtl/sram_port_dpath.sv
module sram_port_dpath #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [DATA_W-1:0] rdata_bus,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  // Request latch: loaded only on the accepting edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
    end
  end

  // Read capture: loaded on the final cycle of a read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= rdata_bus;
    end
  end

endmodule

// File: rtl/sram_port_seq.sv
module sram_port_seq
  import sram_port_pkg::*;
#(
  parameter int RD_WAIT  = 3,
  parameter int WR_PULSE = 2,
  parameter int TURN_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic wr,
  output logic idle,
  output logic accept,
  output logic capture,
  output logic done,
  output logic cs_n,
  output logic oe_n,
  output logic we_n,
  output logic drive
);

  localparam int MAXW  = (RD_WAIT > WR_PULSE)
                         ? ((RD_WAIT > TURN_CYC) ? RD_WAIT : TURN_CYC)
                         : ((WR_PULSE > TURN_CYC) ? WR_PULSE : TURN_CYC);
  localparam int CNT_W = bits_for(MAXW - 1);
  localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_WAIT - 1);
  localparam logic [CNT_W-1:0] WR_LOAD   = CNT_W'(WR_PULSE - 1);
  localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'((TURN_CYC > 0) ? TURN_CYC - 1 : 0);

  seq_st_e          state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;
  logic             done_q, done_d;
  logic             cs_n_q, oe_n_q, we_n_q, drive_q;
  logic             cs_n_d, oe_n_d, we_n_d, drive_d;
  logic             rd_last_q;
  logic             set_rd_last, clr_rd_last;

  assign cnt_zero = (cnt_q == '0);

  // Next-state logic
  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    done_d      = 1'b0;
    set_rd_last = 1'b0;
    clr_rd_last = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (req) begin
          if (wr) begin
            clr_rd_last = 1'b1;
            if (rd_last_q) begin
              state_d = SEQ_TURN;
              cnt_d   = TURN_LOAD;
            end else begin
              state_d = SEQ_WPULSE;
              cnt_d   = WR_LOAD;
            end
          end else begin
            state_d = SEQ_READ;
            cnt_d   = RD_LOAD;
          end
        end
      end
      SEQ_TURN: begin
        if (cnt_zero) begin
          state_d = SEQ_WPULSE;
          cnt_d   = WR_LOAD;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      SEQ_READ: begin
        if (cnt_zero) begin
          state_d     = SEQ_IDLE;
          done_d      = 1'b1;
          set_rd_last = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      SEQ_WPULSE: begin
        if (cnt_zero) begin
          state_d = SEQ_WHOLD;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      SEQ_WHOLD: begin
        state_d = SEQ_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  // Strobes decoded from the next state, then registered (glitch-free pins)
  always_comb begin
    cs_n_d  = !((state_d == SEQ_READ) || (state_d == SEQ_WPULSE) || (state_d == SEQ_WHOLD));
    oe_n_d  = (state_d != SEQ_READ);
    we_n_d  = (state_d != SEQ_WPULSE);
    drive_d = (state_d == SEQ_WPULSE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      drive_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      cs_n_q  <= cs_n_d;
      oe_n_q  <= oe_n_d;
      we_n_q  <= we_n_d;
      drive_q <= drive_d;
    end
  end

  // Read-to-write turnaround flag exists only when turnaround cycles are asked for
  generate
    if (TURN_CYC > 0) begin : g_turn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rd_last_q <= 1'b0;
        end else if (set_rd_last) begin
          rd_last_q <= 1'b1;
        end else if (clr_rd_last) begin
          rd_last_q <= 1'b0;
        end
      end
    end else begin : g_no_turn
      logic unused_flags;
      assign unused_flags = set_rd_last ^ clr_rd_last;
      assign rd_last_q    = 1'b0;
    end
  endgenerate

  assign idle    = (state_q == SEQ_IDLE);
  assign accept  = idle && req;
  assign capture = (state_q == SEQ_READ) && cnt_zero;
  assign done    = done_q;
  assign cs_n    = cs_n_q;
  assign oe_n    = oe_n_q;
  assign we_n    = we_n_q;
  assign drive   = drive_q;

  AST_NO_OE_WE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n_q && !we_n_q)) else $error("OE and WE low together"); // R2

  AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n_q || !we_n_q) |-> !cs_n_q) else $error("strobe without CS"); // R2

  AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    drive_q |-> (!we_n_q && oe_n_q)) else $error("driving outside write pulse"); // R3

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) else $error("done longer than one cycle"); // R8

  AST_ACCEPT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !idle) |=> $stable(cs_n_q) || cs_n_q) else $error("busy request started access"); // R9

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_port_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8,
  parameter int RD_WAIT  = 3,
  parameter int WR_PULSE = 2,
  parameter int TURN_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_idle,
  output logic              host_done,
  output logic [DATA_W-1:0] host_rdata,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int GAP_SAT = TURN_CYC + 1;
  localparam int GAP_W   = bits_for(GAP_SAT);

  logic rst_n_i;
  logic accept;
  logic capture;

  sram_port_rstsync u_rstsync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_i)
  );

  sram_port_seq #(
    .RD_WAIT  (RD_WAIT),
    .WR_PULSE (WR_PULSE),
    .TURN_CYC (TURN_CYC)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .req     (host_req),
    .wr      (host_wr),
    .idle    (host_idle),
    .accept  (accept),
    .capture (capture),
    .done    (host_done),
    .cs_n    (mem_cs_n),
    .oe_n    (mem_oe_n),
    .we_n    (mem_we_n),
    .drive   (mem_dq_oe)
  );

  sram_port_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .accept    (accept),
    .capture   (capture),
    .addr_in   (host_addr),
    .wdata_in  (host_wdata),
    .rdata_bus (mem_dq_in),
    .addr_q    (mem_addr),
    .wdata_q   (mem_dq_out),
    .rdata_q   (host_rdata)
  );

  // Cycles with the memory released (OE high, no drive), saturating
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      gap_q <= GAP_W'(GAP_SAT);
    end else if (!mem_oe_n || mem_dq_oe) begin
      gap_q <= '0;
    end else if (gap_q != GAP_W'(GAP_SAT)) begin
      gap_q <= gap_q + GAP_W'(1);
    end
  end

  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(mem_dq_oe) |-> (gap_q == GAP_W'(GAP_SAT))) else $error("turnaround too short"); // R7

  AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(mem_we_n) |-> (!mem_cs_n && !mem_dq_oe && $stable(mem_addr))) else $error("no hold after WE"); // R6

  AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(mem_we_n) |=> mem_cs_n) else $error("CS not released after hold"); // R6

  AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)))
    else $error("pins moved during access"); // R10

endmodule

// File: tb/sram_port_ctrl_tb.sv
module sram_port_ctrl_tb;

  localparam int CLK_PERIOD = 20;
  localparam int RD_WAIT    = 3;
  localparam int WR_PULSE   = 2;
  localparam int TURN_CYC   = 1;
  localparam int NVEC       = 9;

  // {write flag, address, data (write data or expected read data)}
  localparam logic [23:0] VEC [0:NVEC-1] = '{
    {1'b1, 15'h0003, 8'hA5},
    {1'b0, 15'h0003, 8'hA5},
    {1'b1, 15'h7FC1, 8'h3C},
    {1'b1, 15'h0002, 8'hFF},
    {1'b0, 15'h7FC1, 8'h3C},
    {1'b0, 15'h0002, 8'hFF},
    {1'b0, 15'h0010, 8'h4A},
    {1'b1, 15'h0010, 8'h00},
    {1'b0, 15'h0010, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0;
  logic        host_wr = 1'b0;
  logic [14:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_idle, host_done;
  logic [7:0]  host_rdata;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_port_ctrl #(
    .RD_WAIT (RD_WAIT), .WR_PULSE (WR_PULSE), .TURN_CYC (TURN_CYC)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .host_req (host_req), .host_wr (host_wr),
    .host_addr (host_addr), .host_wdata (host_wdata), .host_idle (host_idle),
    .host_done (host_done), .host_rdata (host_rdata), .mem_cs_n (mem_cs_n),
    .mem_oe_n (mem_oe_n), .mem_we_n (mem_we_n), .mem_addr (mem_addr),
    .mem_dq_out (mem_dq_out), .mem_dq_oe (mem_dq_oe), .mem_dq_in (mem_dq_in)
  );

  // Memory model: 64 bytes on address bits [5:0]; data valid only late in a read
  logic [7:0]  model_mem [0:63];
  logic [14:0] model_wr_addr;
  int          rd_age;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) model_mem[i] <= 8'(i) ^ 8'h5A;
      model_wr_addr <= '0;
      rd_age <= 0;
    end else begin
      if (!mem_cs_n && !mem_we_n && mem_dq_oe) begin
        model_mem[mem_addr[5:0]] <= mem_dq_out;
        model_wr_addr <= mem_addr;
      end
      rd_age <= (!mem_cs_n && !mem_oe_n && mem_we_n) ? rd_age + 1 : 0;
    end
  end

  assign mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n && rd_age >= RD_WAIT - 1)
                     ? model_mem[mem_addr[5:0]] : 8'hEE;

  // Pin monitor, sampled on falling edges
  int oe_run = 0, we_run = 0, last_oe_len = 0, last_we_len = 0;
  int gap_run = 0, last_gap = 0, hold_seen = 0, hold_bad = 0, cs_low_cnt = 0, clash = 0;
  logic        we_prev = 1'b1, oe_prev = 1'b1, dq_prev = 1'b0;
  logic [14:0] addr_prev = '0;

  always @(negedge clk) begin
    if (!mem_oe_n) oe_run++;
    else if (!oe_prev) begin last_oe_len = oe_run; oe_run = 0; end
    if (!mem_we_n) we_run++;
    else if (!we_prev) begin
      last_we_len = we_run; we_run = 0; hold_seen++;
      if (!(!mem_cs_n && mem_addr == addr_prev && !mem_dq_oe)) hold_bad++;
    end
    if (!mem_oe_n) gap_run = 0;
    else if (!mem_dq_oe) gap_run++;
    if (mem_dq_oe && !dq_prev) last_gap = gap_run;
    if (!mem_cs_n) cs_low_cnt++;
    if (!mem_oe_n && (mem_dq_oe || !mem_we_n)) clash++;
    we_prev = mem_we_n; oe_prev = mem_oe_n; dq_prev = mem_dq_oe; addr_prev = mem_addr;
  end

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One access; lat = edges from the accepting edge to done
  task automatic do_op(input logic wr, input logic [14:0] a, input logic [7:0] d,
                       input bit scramble, output int lat, output logic [7:0] rd);
    host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_req = 1'b0;
    if (scramble) begin host_addr = a ^ 15'h0001; host_wdata = ~d; end
    lat = 0;
    do begin
      @(posedge clk); @(negedge clk); #1; lat++;
    end while (!host_done && lat < 64);
    rd = host_rdata;
    @(posedge clk); #1;
    check("R8 done single cycle", int'(host_done), 0);
  endtask

  int          lat;
  logic [7:0]  rd;
  bit          prev_rd;
  int          hold_before, cs_before;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 cs_n in reset", int'(mem_cs_n), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk); #1;
    check("R1 cs_n", int'(mem_cs_n), 1);
    check("R1 oe_n", int'(mem_oe_n), 1);
    check("R1 we_n", int'(mem_we_n), 1);
    check("R1 dq_oe", int'(mem_dq_oe), 0);
    check("R1 idle", int'(host_idle), 1);
    check("R1 done", int'(host_done), 0);

    prev_rd = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      hold_before = hold_seen;
      do_op(VEC[i][23], VEC[i][22:8], VEC[i][7:0], 1'b0, lat, rd);
      if (VEC[i][23]) begin
        check("R5/R7/R11 write latency", lat,
              prev_rd ? TURN_CYC + WR_PULSE + 1 : WR_PULSE + 1);
        check("R5 we low cycles", last_we_len, WR_PULSE);
        check("R5 stored byte", int'(model_mem[VEC[i][13:8]]), int'(VEC[i][7:0]));
        check("R5 full address", int'(model_wr_addr), int'(VEC[i][22:8]));
        check("R6 hold cycle", hold_seen - hold_before, 1);
        if (prev_rd) check("R7 gap after read", int'(last_gap >= TURN_CYC + 1), 1);
      end else begin
        check("R4/R11 read latency", lat, RD_WAIT);
        check("R4 oe low cycles", last_oe_len, RD_WAIT);
        check("R4 read data", int'(rd), int'(VEC[i][7:0]));
      end
      prev_rd = !VEC[i][23];
    end
    check("R6 hold violations", hold_bad, 0);
    check("R2/R3 bus clashes", clash, 0);

    // R9: request held while busy is ignored
    host_req = 1'b1; host_wr = 1'b0; host_addr = 15'h0005;
    @(posedge clk); #1;
    host_wr = 1'b1; host_addr = 15'h0006; host_wdata = 8'h77;
    lat = 0;
    do begin @(posedge clk); @(negedge clk); #1; lat++; end
    while (!host_done && lat < 64);
    host_req = 1'b0;
    check("R9 read under held request", int'(host_rdata), 8'h5F);
    cs_before = cs_low_cnt;
    repeat (4) @(negedge clk); #1;
    check("R9 no extra access", cs_low_cnt - cs_before, 0);
    do_op(1'b0, 15'h0006, 8'h00, 1'b0, lat, rd);
    check("R9 ignored write left byte", int'(rd), 8'h5C);

    // R10: host inputs changing mid-access have no effect
    do_op(1'b1, 15'h0020, 8'h99, 1'b1, lat, rd);
    check("R10 write address", int'(model_wr_addr), 15'h0020);
    do_op(1'b0, 15'h0020, 8'h00, 1'b1, lat, rd);
    check("R10 written byte", int'(rd), 8'h99);
    do_op(1'b0, 15'h0021, 8'h00, 1'b0, lat, rd);
    check("R10 neighbour untouched", int'(rd), 8'h7B);

    // R1: reset in the middle of a write releases every strobe
    host_req = 1'b1; host_wr = 1'b1; host_addr = 15'h0003; host_wdata = 8'hEE;
    @(posedge clk); #1;
    host_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid-write cs_n", int'(mem_cs_n), 1);
    check("R1 mid-write we_n", int'(mem_we_n), 1);
    check("R1 mid-write dq_oe", int'(mem_dq_oe), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk); #1;
    check("R1 idle after reset", int'(host_idle), 1);
    do_op(1'b0, 15'h0003, 8'h00, 1'b0, lat, rd);
    check("R1 read after reset latency", lat, RD_WAIT);
    check("R2/R3 final clash count", clash, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule